// File: doc/BRIEF.md
# Character-Coded Mini Instruction Executor

This block decodes and executes one instruction of a tiny teaching instruction set in which every instruction is written as five 8-bit ASCII characters. The characters are, from the most significant byte down: destination, a literal `=`, first source, operator, second source. Data words are 12 bits wide and there are eight general registers. A source character either names a register, whose value comes from a flattened register-file input, or is a digit that stands for a small immediate constant. The operator selects arithmetic, an unsigned compare, bitwise logic, a constant-building splice, a half-word combine, a conditional clear, a load or a store. Any value-producing operator can steer the program counter instead of a register by naming the jump or branch destination.

The surrounding pipeline presents the instruction with a valid flag, the current PC and the register values. One clock later the block returns the result and exactly one action: a register write, a PC write, a load request or a store request. It returns no action when the instruction cannot be decoded. The memories and the register file itself live outside.

Top module: `mini_exec_unit`

## Requirements
- R1: A source character `a`..`h` selects register index 0..7, where register i occupies bits [i*12 +: 12] of `reg_flat`. A source character `0`..`7` is the zero-extended value 0..7. Any other source character (for example `i` or `8`) makes the instruction a no-op.
- R2: `+`, `-` and `*` give the low 12 bits of the unsigned sum, difference and product. `/` gives the unsigned quotient, and all-ones (0xFFF) when the divisor is zero.
- R3: The compares are unsigned: `=` is equal, `!` is not equal, `<` is less than, `>` is greater than, `[` is less or equal, `]` is greater or equal. Each gives 0xFFF when true and 0x000 when false.
- R4: `&` and `|` give the bitwise AND and OR of the two sources.
- R5: `~` gives {src1[2:0], src2[2:0]} zero-extended. `,` gives {src1[11:6], src2[5:0]}.
- R6: `?` gives 0 when src2 is nonzero and src1 when src2 is zero.
- R7: For a value-producing operator, a destination `a`..`h` raises `wr_en` with `wr_idx` 0..7 and the result on `result`. A destination `0` produces no action at all.
- R8: Destination `P` raises `pc_wr_en` with `pc_next` equal to the result. Destination `p` raises `pc_wr_en` with `pc_next` = `pc_in` + 1 + result, where the result is taken as a signed 12-bit value and the sum wraps at 12 bits.
- R9: `)` raises `ld_req` with `mem_addr` = src1 + src2 and the target register on `wr_idx`, without `wr_en`. A load whose destination is not a register is a no-op.
- R10: `(` raises `st_req` with `mem_addr` = src2 and the store data (src1) on `result`. The destination character is ignored, and no register or PC write happens.
- R11: If the second character is not `=`, or the operator or destination character is unknown, the instruction is a no-op with all four action outputs low. At most one action output is ever high.
- R12: Outputs are registered, so they appear one cycle after `in_valid` is sampled high. An idle cycle (`in_valid` low) and reset both yield `out_valid` low and all actions low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| instr | input | 40 | Five ASCII characters: dest, '=', src1, op, src2 (MSB first) |
| pc_in | input | 12 | PC of the presented instruction |
| reg_flat | input | 96 | All eight register values, register i at [i*12 +: 12] |
| out_valid | output | 1 | Registered copy of in_valid |
| result | output | 12 | Operation result, or store data |
| wr_en | output | 1 | Register write request |
| wr_idx | output | 3 | Target register of a write or a load |
| pc_wr_en | output | 1 | PC write request |
| pc_next | output | 12 | New PC value when pc_wr_en is high |
| ld_req | output | 1 | Load request |
| st_req | output | 1 | Store request |
| mem_addr | output | 12 | Load or store address |

## Verification
On every cycle the assertions check several properties. At most one action fires. An idle output cycle carries no action. Every compare result written back is either all-zeros or all-ones. A zero divisor always yields all-ones. A relative PC write always lands at the old PC plus one plus the signed result. What the assertions cannot show is whether each character maps to the right operation, register index or immediate value, and what each operator computes. The bench's table of encoded instructions against hand-computed results covers that, together with the no-op rejections and the reset and idle scenarios.

// File: rtl/mini_exec_pkg.sv
package mini_exec_pkg;

   localparam int CHAR_W = 8;

   typedef enum logic [4:0] {
      OPK_ADD, OPK_SUB, OPK_MUL, OPK_DIV,
      OPK_EQ, OPK_NE, OPK_LT, OPK_GT, OPK_LE, OPK_GE,
      OPK_AND, OPK_OR, OPK_SPLICE, OPK_COMBINE, OPK_COND,
      OPK_LOAD, OPK_STORE, OPK_BAD
   } op_kind_e;

   typedef enum logic [2:0] {
      DK_REG, DK_NONE, DK_ABS, DK_REL, DK_BAD
   } dst_kind_e;

   // Map an operator character to its operation class.
   function automatic op_kind_e op_of(input logic [CHAR_W-1:0] c, input bit div_on);
      op_kind_e k;
      case (c)
         "+": k = OPK_ADD;
         "-": k = OPK_SUB;
         "*": k = OPK_MUL;
         "/": k = div_on ? OPK_DIV : OPK_BAD;
         "=": k = OPK_EQ;
         "!": k = OPK_NE;
         "<": k = OPK_LT;
         ">": k = OPK_GT;
         "[": k = OPK_LE;
         "]": k = OPK_GE;
         "&": k = OPK_AND;
         "|": k = OPK_OR;
         "~": k = OPK_SPLICE;
         ",": k = OPK_COMBINE;
         "?": k = OPK_COND;
         ")": k = OPK_LOAD;
         "(": k = OPK_STORE;
         default: k = OPK_BAD;
      endcase
      return k;
   endfunction

   function automatic bit is_compare(input op_kind_e k);
      return (k == OPK_EQ) || (k == OPK_NE) || (k == OPK_LT) ||
             (k == OPK_GT) || (k == OPK_LE) || (k == OPK_GE);
   endfunction

endpackage

// File: rtl/mini_src_decode.sv
module mini_src_decode #(
   parameter int WORD_W   = 12,
   parameter int NUM_REGS = 8,
   parameter int IMM_W    = 3
) (
   input  logic [mini_exec_pkg::CHAR_W-1:0] sel_char,
   input  logic [NUM_REGS*WORD_W-1:0]       reg_flat,
   output logic [WORD_W-1:0]                value,
   output logic                             ok
);
   localparam int CW      = mini_exec_pkg::CHAR_W;
   localparam int IMM_CNT = 2 ** IMM_W;

   logic [CW-1:0] reg_off;
   logic [CW-1:0] imm_off;

   assign reg_off = sel_char - CW'("a");
   assign imm_off = sel_char - CW'("0");

   always_comb begin
      value = '0;
      ok    = 1'b0;
      if (sel_char >= CW'("a") && reg_off < CW'(NUM_REGS)) begin
         ok = 1'b1;
         for (int i = 0; i < NUM_REGS; i++) begin
            if (reg_off == CW'(i)) value = reg_flat[i*WORD_W +: WORD_W];
         end
      end else if (sel_char >= CW'("0") && imm_off < CW'(IMM_CNT)) begin
         ok    = 1'b1;
         value = WORD_W'(imm_off);
      end
   end
endmodule

// File: rtl/mini_dest_decode.sv
module mini_dest_decode #(
   parameter int NUM_REGS = 8,
   parameter int IDX_W    = 3
) (
   input  logic [mini_exec_pkg::CHAR_W-1:0] dst_char,
   output mini_exec_pkg::dst_kind_e         kind,
   output logic [IDX_W-1:0]                 idx
);
   import mini_exec_pkg::*;
   localparam int CW = CHAR_W;

   logic [CW-1:0] off;
   assign off = dst_char - CW'("a");

   always_comb begin
      idx  = '0;
      kind = DK_BAD;
      if (dst_char == CW'("0"))      kind = DK_NONE;
      else if (dst_char == CW'("P")) kind = DK_ABS;
      else if (dst_char == CW'("p")) kind = DK_REL;
      else if (dst_char >= CW'("a") && off < CW'(NUM_REGS)) begin
         kind = DK_REG;
         idx  = IDX_W'(off);
      end
   end
endmodule

// File: rtl/mini_alu.sv
module mini_alu #(
   parameter int WORD_W  = 12,
   parameter int IMM_W   = 3,
   parameter bit HAS_DIV = 1'b1
) (
   input  mini_exec_pkg::op_kind_e op,
   input  logic [WORD_W-1:0]       a,
   input  logic [WORD_W-1:0]       b,
   output logic [WORD_W-1:0]       res
);
   import mini_exec_pkg::*;
   localparam int HALF = WORD_W / 2;
   localparam int PAD  = WORD_W - 2 * IMM_W;

   logic [WORD_W-1:0] quo;
   logic [WORD_W-1:0] all1;
   assign all1 = '1;

   // Divider variant chosen by parameter.
   if (HAS_DIV) begin : g_div
      assign quo = (b == '0) ? all1 : a / b;
   end else begin : g_no_div
      assign quo = '0;
   end

   always_comb begin
      case (op)
         OPK_ADD:     res = a + b;
         OPK_SUB:     res = a - b;
         OPK_MUL:     res = a * b;
         OPK_DIV:     res = quo;
         OPK_EQ:      res = (a == b) ? all1 : '0;
         OPK_NE:      res = (a != b) ? all1 : '0;
         OPK_LT:      res = (a <  b) ? all1 : '0;
         OPK_GT:      res = (a >  b) ? all1 : '0;
         OPK_LE:      res = (a <= b) ? all1 : '0;
         OPK_GE:      res = (a >= b) ? all1 : '0;
         OPK_AND:     res = a & b;
         OPK_OR:      res = a | b;
         OPK_SPLICE:  res = {PAD'(0), a[IMM_W-1:0], b[IMM_W-1:0]};
         OPK_COMBINE: res = {a[WORD_W-1:HALF], b[HALF-1:0]};
         OPK_COND:    res = (b != '0) ? '0 : a;
         OPK_STORE:   res = a;
         OPK_LOAD:    res = a + b;
         default:     res = '0;
      endcase
   end
endmodule

// File: rtl/mini_exec_unit.sv
module mini_exec_unit #(
   parameter int WORD_W   = 12,
   parameter int NUM_REGS = 8,
   parameter int IMM_W    = 3,
   parameter bit HAS_DIV  = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       in_valid,
   input  logic [39:0]                instr,
   input  logic [WORD_W-1:0]          pc_in,
   input  logic [NUM_REGS*WORD_W-1:0] reg_flat,
   output logic                       out_valid,
   output logic [WORD_W-1:0]          result,
   output logic                       wr_en,
   output logic [$clog2(NUM_REGS)-1:0] wr_idx,
   output logic                       pc_wr_en,
   output logic [WORD_W-1:0]          pc_next,
   output logic                       ld_req,
   output logic                       st_req,
   output logic [WORD_W-1:0]          mem_addr
);
   import mini_exec_pkg::*;
   localparam int IDX_W = $clog2(NUM_REGS);
   localparam int CW    = CHAR_W;

   // Elaboration-time parameter checks.
   if (NUM_REGS < 2 || NUM_REGS > 8) begin : g_bad_regs
      $error("NUM_REGS must lie in 2..8");
   end
   if (WORD_W % 2 != 0 || WORD_W <= 2 * IMM_W) begin : g_bad_word
      $error("WORD_W must be even and wider than two immediates");
   end
   if (IMM_W < 1 || IMM_W > 3) begin : g_bad_imm
      $error("IMM_W must lie in 1..3");
   end

   // Field split, most significant character first.
   logic [CW-1:0] c_dst, c_eq, c_op;
   logic [CW-1:0] c_src [2];
   assign c_dst    = instr[39:32];
   assign c_eq     = instr[31:24];
   assign c_src[0] = instr[23:16];
   assign c_op     = instr[15:8];
   assign c_src[1] = instr[7:0];

   // Source operand decoders.
   logic [WORD_W-1:0] src_val [2];
   logic              src_ok  [2];
   for (genvar gi = 0; gi < 2; gi++) begin : g_src
      mini_src_decode #(.WORD_W(WORD_W), .NUM_REGS(NUM_REGS), .IMM_W(IMM_W)) i_src (
         .sel_char (c_src[gi]),
         .reg_flat (reg_flat),
         .value    (src_val[gi]),
         .ok       (src_ok[gi])
      );
   end

   dst_kind_e        dkind;
   logic [IDX_W-1:0] didx;
   mini_dest_decode #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) i_dst (
      .dst_char (c_dst),
      .kind     (dkind),
      .idx      (didx)
   );

   op_kind_e opk;
   assign opk = op_of(c_op, HAS_DIV);

   logic [WORD_W-1:0] alu_res;
   mini_alu #(.WORD_W(WORD_W), .IMM_W(IMM_W), .HAS_DIV(HAS_DIV)) i_alu (
      .op  (opk),
      .a   (src_val[0]),
      .b   (src_val[1]),
      .res (alu_res)
   );

   // Action selection.
   logic core_ok, is_mem, act_wr, act_pc, act_ld, act_st;
   logic [WORD_W-1:0] pc_d, addr_d;

   assign core_ok = (c_eq == CW'("=")) && src_ok[0] && src_ok[1] && (opk != OPK_BAD);
   assign is_mem  = (opk == OPK_LOAD) || (opk == OPK_STORE);
   assign act_st  = core_ok && (opk == OPK_STORE);
   assign act_ld  = core_ok && (opk == OPK_LOAD) && (dkind == DK_REG);
   assign act_wr  = core_ok && !is_mem && (dkind == DK_REG);
   assign act_pc  = core_ok && !is_mem && ((dkind == DK_ABS) || (dkind == DK_REL));
   assign pc_d    = (dkind == DK_ABS) ? alu_res : pc_in + WORD_W'(1) + alu_res;
   assign addr_d  = (opk == OPK_LOAD) ? alu_res : src_val[1];

   // Output register stage; check-only state alongside.
   logic              cmp_q, div_q, bzero_q, rel_q;
   logic [WORD_W-1:0] pc_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         wr_en     <= 1'b0;
         pc_wr_en  <= 1'b0;
         ld_req    <= 1'b0;
         st_req    <= 1'b0;
         result    <= '0;
         wr_idx    <= '0;
         pc_next   <= '0;
         mem_addr  <= '0;
         cmp_q     <= 1'b0;
         div_q     <= 1'b0;
         bzero_q   <= 1'b0;
         rel_q     <= 1'b0;
         pc_q      <= '0;
      end else begin
         out_valid <= in_valid;
         wr_en     <= in_valid && act_wr;
         pc_wr_en  <= in_valid && act_pc;
         ld_req    <= in_valid && act_ld;
         st_req    <= in_valid && act_st;
         result    <= alu_res;
         wr_idx    <= didx;
         pc_next   <= pc_d;
         mem_addr  <= addr_d;
         cmp_q     <= is_compare(opk);
         div_q     <= (opk == OPK_DIV);
         bzero_q   <= (src_val[1] == '0);
         rel_q     <= (dkind == DK_REL);
         pc_q      <= pc_in;
      end
   end

   // R11: never more than one action at a time.
   assert_single_action_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wr_en, pc_wr_en, ld_req, st_req}));

   // R12: an idle output cycle carries no action.
   assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> !(wr_en || pc_wr_en || ld_req || st_req));

   // R3: compare results are all-zeros or all-ones.
   assert_cmp_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_q && (wr_en || pc_wr_en)) |-> (result == '0 || result == '1));

   // R2: zero divisor gives all-ones.
   assert_div_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (div_q && bzero_q && (wr_en || pc_wr_en)) |-> (result == '1));

   // R8: relative target is old PC + 1 + signed result.
   assert_rel_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_wr_en && rel_q) |-> (pc_next == WORD_W'(pc_q + WORD_W'(1) + result)));

endmodule

// File: tb/test_mini_exec_unit.sv
`timescale 1ns/100ps
module test_mini_exec_unit;

   typedef struct packed {
      logic [39:0] instr;
      logic [3:0]  flags;   // {wr, pc, ld, st}
      logic [2:0]  idx;
      logic [11:0] res;
      logic [11:0] pc;
      logic [11:0] addr;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 36;
   // Registers: a=005 b=003 c=FFF d=000 e=800 f=123 g=7C0 h=010; pc_in=020
   localparam vec_t VECS [NV] = '{
      '{"c=a+b", 4'b1000, 3'd2, 12'h008, 12'h000, 12'h000, 8'd2},  // R2
      '{"c=b-a", 4'b1000, 3'd2, 12'hFFE, 12'h000, 12'h000, 8'd2},  // R2
      '{"c=a*b", 4'b1000, 3'd2, 12'h00F, 12'h000, 12'h000, 8'd2},  // R2
      '{"c=c*c", 4'b1000, 3'd2, 12'h001, 12'h000, 12'h000, 8'd2},  // R2
      '{"c=c/b", 4'b1000, 3'd2, 12'h555, 12'h000, 12'h000, 8'd2},  // R2
      '{"c=a/0", 4'b1000, 3'd2, 12'hFFF, 12'h000, 12'h000, 8'd2},  // R2 div by zero
      '{"a=e+e", 4'b1000, 3'd0, 12'h000, 12'h000, 12'h000, 8'd2},  // R2 wrap
      '{"c=a<b", 4'b1000, 3'd2, 12'h000, 12'h000, 12'h000, 8'd3},  // R3
      '{"c=b<a", 4'b1000, 3'd2, 12'hFFF, 12'h000, 12'h000, 8'd3},  // R3
      '{"c=c>a", 4'b1000, 3'd2, 12'hFFF, 12'h000, 12'h000, 8'd3},  // R3 unsigned
      '{"c=a=5", 4'b1000, 3'd2, 12'hFFF, 12'h000, 12'h000, 8'd3},  // R3
      '{"c=a!5", 4'b1000, 3'd2, 12'h000, 12'h000, 12'h000, 8'd3},  // R3
      '{"c=a[5", 4'b1000, 3'd2, 12'hFFF, 12'h000, 12'h000, 8'd3},  // R3
      '{"c=b]a", 4'b1000, 3'd2, 12'h000, 12'h000, 12'h000, 8'd3},  // R3
      '{"c=f&g", 4'b1000, 3'd2, 12'h100, 12'h000, 12'h000, 8'd4},  // R4
      '{"c=f|h", 4'b1000, 3'd2, 12'h133, 12'h000, 12'h000, 8'd4},  // R4
      '{"c=2~7", 4'b1000, 3'd2, 12'h017, 12'h000, 12'h000, 8'd5},  // R5
      '{"c=f~a", 4'b1000, 3'd2, 12'h01D, 12'h000, 12'h000, 8'd5},  // R5
      '{"c=g,f", 4'b1000, 3'd2, 12'h7E3, 12'h000, 12'h000, 8'd5},  // R5
      '{"c=f?d", 4'b1000, 3'd2, 12'h123, 12'h000, 12'h000, 8'd6},  // R6
      '{"c=f?a", 4'b1000, 3'd2, 12'h000, 12'h000, 12'h000, 8'd6},  // R6
      '{"h=7+7", 4'b1000, 3'd7, 12'h00E, 12'h000, 12'h000, 8'd7},  // R7 / R1
      '{"0=a+b", 4'b0000, 3'd0, 12'h000, 12'h000, 12'h000, 8'd7},  // R7 no write
      '{"P=f+0", 4'b0100, 3'd0, 12'h123, 12'h123, 12'h000, 8'd8},  // R8
      '{"p=0-2", 4'b0100, 3'd0, 12'hFFE, 12'h01F, 12'h000, 8'd8},  // R8 backwards
      '{"p=c?d", 4'b0100, 3'd0, 12'hFFF, 12'h020, 12'h000, 8'd8},  // R8
      '{"d=a)b", 4'b0010, 3'd3, 12'h000, 12'h000, 12'h008, 8'd9},  // R9
      '{"P=a)b", 4'b0000, 3'd0, 12'h000, 12'h000, 12'h000, 8'd9},  // R9 bad dest
      '{"0=f(h", 4'b0001, 3'd0, 12'h123, 12'h000, 12'h010, 8'd10}, // R10
      '{"Q=f(h", 4'b0001, 3'd0, 12'h123, 12'h000, 12'h010, 8'd10}, // R10 dest ignored
      '{"c=a@b", 4'b0000, 3'd0, 12'h000, 12'h000, 12'h000, 8'd11}, // R11
      '{"x=a+b", 4'b0000, 3'd0, 12'h000, 12'h000, 12'h000, 8'd11}, // R11
      '{"c-a+b", 4'b0000, 3'd0, 12'h000, 12'h000, 12'h000, 8'd11}, // R11
      '{"c=i+a", 4'b0000, 3'd0, 12'h000, 12'h000, 12'h000, 8'd1},  // R1 past h
      '{"c=a+8", 4'b0000, 3'd0, 12'h000, 12'h000, 12'h000, 8'd1},  // R1 past 7
      '{"c=z+b", 4'b0000, 3'd0, 12'h000, 12'h000, 12'h000, 8'd1}   // R1
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [39:0] instr = '0;
   logic [11:0] pc_in = 12'h020;
   logic [95:0] reg_flat;
   logic        out_valid, wr_en, pc_wr_en, ld_req, st_req;
   logic [11:0] result, pc_next, mem_addr;
   logic [2:0]  wr_idx;

   int n_checks = 0;
   int n_fails  = 0;

   assign reg_flat = {12'h010, 12'h7C0, 12'h123, 12'h800,
                      12'h000, 12'hFFF, 12'h003, 12'h005};

   always #2.5 clk = ~clk;

   mini_exec_unit i_mini_exec_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
      .pc_in(pc_in), .reg_flat(reg_flat), .out_valid(out_valid),
      .result(result), .wr_en(wr_en), .wr_idx(wr_idx), .pc_wr_en(pc_wr_en),
      .pc_next(pc_next), .ld_req(ld_req), .st_req(st_req), .mem_addr(mem_addr)
   );

   function automatic logic [3:0] act_flags();
      return {wr_en, pc_wr_en, ld_req, st_req};
   endfunction

   task automatic check(input string tag, input logic ok, input string detail);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: %s", tag, detail);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   endtask

   initial begin
      #250000;
      n_fails++;
      $display("FAIL watchdog: act=timeout exp=completion");
      summary();
   end

   initial begin
      // R12: reset holds everything quiet even with a valid instruction presented.
      in_valid = 1'b1;
      instr    = "c=a+b";
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R12 reset", !out_valid && act_flags() == 4'b0000,
            $sformatf("act valid=%b flags=%b exp valid=0 flags=0000", out_valid, act_flags()));
      rst_n    = 1'b1;
      in_valid = 1'b0;

      // R12: idle cycle gives no action.
      @(posedge clk);
      @(negedge clk);
      check("R12 idle", !out_valid && act_flags() == 4'b0000,
            $sformatf("act valid=%b flags=%b exp valid=0 flags=0000", out_valid, act_flags()));

      // Table walk: drive at negedge, registered result visible at next negedge.
      for (int v = 0; v < NV; v++) begin
         logic ok;
         vec_t e;
         e        = VECS[v];
         in_valid = 1'b1;
         instr    = e.instr;
         @(posedge clk);
         @(negedge clk);
         ok = out_valid && (act_flags() == e.flags);
         if (e.flags[3] || e.flags[1]) ok = ok && (wr_idx == e.idx);
         if (e.flags[3] || e.flags[2] || e.flags[0]) ok = ok && (result == e.res);
         if (e.flags[2]) ok = ok && (pc_next == e.pc);
         if (e.flags[1] || e.flags[0]) ok = ok && (mem_addr == e.addr);
         check($sformatf("R%0d '%s'", e.req, e.instr), ok,
               $sformatf("act v=%b fl=%b idx=%0d res=%h pc=%h addr=%h exp fl=%b idx=%0d res=%h pc=%h addr=%h",
                         out_valid, act_flags(), wr_idx, result, pc_next, mem_addr,
                         e.flags, e.idx, e.res, e.pc, e.addr));
      end

      // R12: dropping in_valid silences the next output cycle.
      in_valid = 1'b0;
      instr    = "c=a+b";
      @(posedge clk);
      @(negedge clk);
      check("R12 valid low", !out_valid && act_flags() == 4'b0000,
            $sformatf("act valid=%b flags=%b exp valid=0 flags=0000", out_valid, act_flags()));

      // R8: relative branch from a different PC, forward.
      in_valid = 1'b1;
      pc_in    = 12'hFFE;
      instr    = "p=0+3";
      @(posedge clk);
      @(negedge clk);
      check("R8 wrap", pc_wr_en && pc_next == 12'h002,
            $sformatf("act pcw=%b pc=%h exp pcw=1 pc=002", pc_wr_en, pc_next));

      // R12: reset mid-stream clears a pending action.
      rst_n = 1'b0;
      @(posedge clk);
      @(negedge clk);
      check("R12 reset mid", act_flags() == 4'b0000 && !out_valid,
            $sformatf("act valid=%b flags=%b exp valid=0 flags=0000", out_valid, act_flags()));
      summary();
   end

endmodule